// File: doc/BRIEF.md
# Multi-mode TDM audio serial master

This block produces the serial side of a four-channel audio converter that owns the clocks. It runs from a master clock at 512 times the sample rate and divides it into a bit clock and a frame clock, then shifts four parallel channel samples out on two serial lines. Two mode pins choose between a two-line layout with two channels per line and two time-division layouts that put all four channels on the first line at different bit-clock rates.

Each frame is 512 master-clock cycles long. The samples and the mode pins are captured once per frame, on the frame boundary. After the active-low power-down input is released, the clocks run at once, but the data lines stay at zero until a set number of frame-clock rising edges have been seen. The bit clock always has a 50% duty cycle. The frame clock and the data change only where the bit clock falls.

Top module: `tdm_audio_master`

## Requirements
- R1: The mode pins `mode_sel` decode as 2'b00 two-line mode, 2'b01 wide TDM mode, and 2'b11 narrow TDM mode. 2'b10 behaves exactly like 2'b00.
- R2: The bit clock period is 8 master-clock cycles in two-line mode, 2 in wide TDM mode and 4 in narrow TDM mode. Each period is low for the first half and high for the second half, and a frame spans 512 master-clock cycles.
- R3: `lrck`, `sdo1` and `sdo2` change only in the cycle where `bclk` falls.
- R4: In two-line mode, `lrck` is high for the first 32 bits of the frame and low for the last 32. `sdo1` carries channel 0 then channel 1, and `sdo2` carries channel 2 then channel 3.
- R5: In both TDM modes, `lrck` is high for the first 32-bit slot only. `sdo1` carries channels 0 to 3 in slots 0 to 3, and every later slot is zero.
- R6: In narrow TDM mode `sdo2` is held low. In wide TDM mode `sdo2` repeats the `sdo1` stream bit for bit.
- R7: Each slot sends its sample MSB first from the slot's first bit, and the bits after the sample width are zero.
- R8: While `pdn_n` is low, `bclk`, `lrck`, `sdo1` and `sdo2` are all low.
- R9: After `pdn_n` rises, the frame that opens with frame-clock rising edge number SETTLE_FRAMES is the first to carry data. Both data lines are zero in every earlier frame.
- R10: The samples and the mode are captured in the last master-clock cycle of each frame. Changes at any other time have no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, 512 times the sample rate |
| pdn_n | input | 1 | Active-low power-down, asynchronous reset |
| mode_sel | input | 2 | Framing mode select |
| ch0 | input | SAMPLE_W | Channel 0 sample |
| ch1 | input | SAMPLE_W | Channel 1 sample |
| ch2 | input | SAMPLE_W | Channel 2 sample |
| ch3 | input | SAMPLE_W | Channel 3 sample |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Frame clock |
| sdo1 | output | 1 | First serial data line |
| sdo2 | output | 1 | Second serial data line |

## Verification
The bench keeps SAMPLE_W at 24 and lowers SETTLE_FRAMES from 516 to 3. With the default, the mute window alone would last about 264,000 master-clock cycles. With 3, the release frame and the first data-bearing frame both fall inside a short run, and a second power-down pulse repeats the sequence. All four mode codes, frame-boundary mode switches, all-ones and single-bit samples, and mid-frame sample changes then fit in about twenty frames.

// File: rtl/tdm_audio_master.sv
module tdm_audio_master #(
  parameter int SAMPLE_W      = 24,
  parameter int SETTLE_FRAMES = 516
) (
  input  logic                mclk,
  input  logic                pdn_n,
  input  logic [1:0]          mode_sel,
  input  logic [SAMPLE_W-1:0] ch0,
  input  logic [SAMPLE_W-1:0] ch1,
  input  logic [SAMPLE_W-1:0] ch2,
  input  logic [SAMPLE_W-1:0] ch3,
  output logic                bclk,
  output logic                lrck,
  output logic                sdo1,
  output logic                sdo2
);

  localparam int CNT_W = 9;
  localparam int FC_W  = $clog2(SETTLE_FRAMES + 1);
  localparam logic [1:0] M_TWO  = 2'b00;
  localparam logic [1:0] M_WIDE = 2'b01;
  localparam logic [1:0] M_NARR = 2'b11;

  logic [CNT_W-1:0]             cnt;
  logic [1:0]                   mode_q;
  logic [3:0][SAMPLE_W-1:0]     smp_q;
  logic [FC_W-1:0]              fcnt;

  wire       frame_end = (cnt == '1);
  wire       frame_beg = (cnt == '0);
  wire [1:0] mode_in   = (mode_sel == 2'b10) ? M_TWO : mode_sel;

  always_ff @(posedge mclk or negedge pdn_n) begin
    if (!pdn_n) begin
      cnt    <= '1;
      mode_q <= M_TWO;
      smp_q  <= '0;
      fcnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (frame_end) begin
        mode_q <= mode_in;
        smp_q  <= {ch3, ch2, ch1, ch0};
      end
      if (frame_beg && int'(fcnt) < SETTLE_FRAMES)
        fcnt <= fcnt + 1'b1;
    end
  end

  function automatic logic pick(input logic [SAMPLE_W-1:0] s, input logic [4:0] p);
    int idx;
    idx = SAMPLE_W - 1 - int'(p);
    if (idx >= 0 && idx < SAMPLE_W) return s[idx];
    return 1'b0;
  endfunction

  logic       bclk_d, d1, d2;
  logic [7:0] bidx;
  wire  [2:0] slot = bidx[7:5];
  wire  [4:0] pos  = bidx[4:0];

  always_comb begin
    case (mode_q)
      M_WIDE:  begin bclk_d = cnt[0]; bidx = cnt[8:1]; end
      M_NARR:  begin bclk_d = cnt[1]; bidx = {1'b0, cnt[8:2]}; end
      default: begin bclk_d = cnt[2]; bidx = {2'b00, cnt[8:3]}; end
    endcase
    if (mode_q == M_TWO) begin
      d1 = pick(smp_q[{1'b0, slot[0]}], pos);
      d2 = pick(smp_q[{1'b1, slot[0]}], pos);
    end else begin
      d1 = (slot < 3'd4) ? pick(smp_q[slot[1:0]], pos) : 1'b0;
      d2 = (mode_q == M_NARR) ? 1'b0 : d1;
    end
  end

  wire data_on = frame_beg ? (int'(fcnt) + 1 >= SETTLE_FRAMES)
                           : (int'(fcnt) >= SETTLE_FRAMES);

  always_ff @(posedge mclk or negedge pdn_n) begin
    if (!pdn_n) begin
      bclk <= 1'b0;
      lrck <= 1'b0;
      sdo1 <= 1'b0;
      sdo2 <= 1'b0;
    end else begin
      bclk <= bclk_d;
      lrck <= (slot == 3'd0);
      sdo1 <= data_on & d1;
      sdo2 <= data_on & d2;
    end
  end

  AST_LRCK_ON_FALL: assert property (@(posedge mclk) disable iff (!pdn_n)
    !$stable(lrck) |-> $fell(bclk)); // R3
  AST_DATA_ON_FALL: assert property (@(posedge mclk) disable iff (!pdn_n)
    (!$stable(sdo1) || !$stable(sdo2)) |-> $fell(bclk)); // R3
  AST_NARROW_SD2_LOW: assert property (@(posedge mclk) disable iff (!pdn_n)
    (mode_q == M_NARR) |=> !sdo2); // R6
  AST_MUTE_WINDOW: assert property (@(posedge mclk) disable iff (!pdn_n)
    (int'(fcnt) + 1 < SETTLE_FRAMES) |=> (!sdo1 && !sdo2)); // R9
  AST_MODE_HOLD: assert property (@(posedge mclk) disable iff (!pdn_n)
    !frame_end |=> $stable(mode_q)); // R10

endmodule

// File: tb/test_tdm_audio_master.sv
module test_tdm_audio_master;
  localparam int SW = 24;
  localparam int ST = 3;

  logic mclk = 1'b0;
  always #2 mclk = ~mclk;

  logic          pdn_n;
  logic [1:0]    mode_sel;
  logic [SW-1:0] c0, c1, c2, c3;
  wire           bclk, lrck, sdo1, sdo2;

  int total = 0;
  int bad   = 0;
  logic [1:0]    m_mode;
  logic [SW-1:0] m_s [4];

  tdm_audio_master #(.SAMPLE_W(SW), .SETTLE_FRAMES(ST)) i_tdm_audio_master (
    .mclk(mclk), .pdn_n(pdn_n), .mode_sel(mode_sel),
    .ch0(c0), .ch1(c1), .ch2(c2), .ch3(c3),
    .bclk(bclk), .lrck(lrck), .sdo1(sdo1), .sdo2(sdo2));

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] dec(input logic [1:0] m);
    return (m == 2'b10) ? 2'b00 : m;
  endfunction

  function automatic int bit_no(input logic [1:0] m, input int c);
    case (m)
      2'b01:   return c / 2;
      2'b11:   return c / 4;
      default: return c / 8;
    endcase
  endfunction

  function automatic logic e_bclk(input logic [1:0] m, input int c);
    case (m)
      2'b01:   return (c % 2) >= 1;
      2'b11:   return (c % 4) >= 2;
      default: return (c % 8) >= 4;
    endcase
  endfunction

  function automatic logic sbit(input logic [SW-1:0] s, input int p);
    return (p < SW) ? s[SW-1-p] : 1'b0;
  endfunction

  function automatic logic e_sd(input logic [1:0] m, input int c, input bit line2);
    int b, slot, pos;
    b = bit_no(m, c); slot = b / 32; pos = b % 32;
    if (m == 2'b00) return sbit(m_s[slot + (line2 ? 2 : 0)], pos);
    if (slot >= 4) return 1'b0;
    if (line2 && m == 2'b11) return 1'b0;
    return sbit(m_s[slot], pos);
  endfunction

  task automatic set_inputs(input int f);
    logic [1:0] dir [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
    if (f >= ST && f < ST + 4) mode_sel = dir[f-ST];
    else mode_sel = 2'($urandom);
    if (f == ST) begin
      c0 = '1; c1 = 24'h800001; c2 = 24'h000001; c3 = 24'hA5A5A5;
    end else if (f == ST + 1) begin
      c0 = 24'h000001; c1 = '1; c2 = 24'h800000; c3 = 24'h5A5A5A;
    end else begin
      c0 = SW'($urandom); c1 = SW'($urandom); c2 = SW'($urandom); c3 = SW'($urandom);
    end
  endtask

  task automatic check_reset(input string when);
    chk({"R8 bclk ", when}, bclk, 1'b0);
    chk({"R8 lrck ", when}, lrck, 1'b0);
    chk({"R8 sdo1 ", when}, sdo1, 1'b0);
    chk({"R8 sdo2 ", when}, sdo2, 1'b0);
  endtask

  task automatic run(input int nframes);
    for (int j = 1; j <= nframes * 512 + 1; j++) begin
      @(posedge mclk);
      #1;
      if (j >= 2) begin
        int c, fr;
        bit on;
        c = (j - 2) % 512;
        fr = (j - 2) / 512 + 1;
        on = (fr >= ST);
        chk("R1 R2 bclk", bclk, e_bclk(m_mode, c));
        chk((m_mode == 2'b00) ? "R4 lrck" : "R5 lrck", lrck, bit_no(m_mode, c) / 32 == 0);
        chk(on ? "R7 R10 R4 R5 sdo1" : "R9 sdo1 muted", sdo1, on && e_sd(m_mode, c, 1'b0));
        chk(on ? "R6 R4 sdo2" : "R9 sdo2 muted", sdo2, on && e_sd(m_mode, c, 1'b1));
      end
      if ((j - 1) % 512 == 0) begin
        m_mode = dec(mode_sel);
        m_s[0] = c0; m_s[1] = c1; m_s[2] = c2; m_s[3] = c3;
      end
      #1;
      if (j % 512 == 100) begin
        c0 = SW'($urandom); c2 = SW'($urandom); mode_sel = 2'($urandom);
      end
      if (j % 512 == 300) set_inputs((j - 2) / 512 + 2);
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_A0D1));
    pdn_n = 1'b0;
    set_inputs(1);
    m_mode = 2'b00;
    repeat (3) @(posedge mclk);
    #1 check_reset("initial");
    #1 pdn_n = 1'b1;
    run(ST + 16);
    @(posedge mclk);
    #2 pdn_n = 1'b0;
    #1 check_reset("async");
    @(posedge mclk);
    #1 check_reset("held");
    set_inputs(ST);
    #1 pdn_n = 1'b1;
    run(ST + 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule